// File: doc/BRIEF.md
# NAND Controller Status and Interrupt Unit

This block holds the event and interrupt state of a NAND flash controller. A sequencer elsewhere in the controller reports two completion pulses: one when a data transfer finishes and one when a command phase finishes. The flash ready/busy line comes in asynchronously. The unit latches the two pulses as sticky status bits. It synchronises the ready/busy line and records each busy-to-ready transition as a third sticky event. It raises one interrupt line whenever a latched event is also enabled in the interrupt mask.

Software reaches the unit through a simple register port with byte offsets and a 32-bit word. That port gives access to the following:
- Control strobes that switch the controller on and off.
- The status word. Reading it clears the events.
- Write-one-to-set and write-one-to-clear ports for the interrupt mask, plus a read-only view of the mask.
- A register holding the first of five address bytes.
- A one-bit bank selector.

Top module: `flash_status_irq`

## Requirements
- R1: After reset, the interrupt, the controller-on output, the first-address byte and the bank select are all 0. The status word and the mask both read 0.
- R2: A write to offset 0x04 with bit 0 set turns the controller-on output to 1 from the next cycle. A write with bit 1 set turns it to 0 from the next cycle. When both bits are set, turning off wins. Offset 0x04 reads as 0.
- R3: A one-cycle transfer-done pulse sets status bit 16, and a one-cycle command-done pulse sets status bit 17. Each bit is visible from the cycle after the pulse, and it stays set until the status word is read.
- R4: The ready/busy input (1 = ready) passes through a two-flop synchroniser. A 0-to-1 transition on it sets status bit 24 in the third cycle after the input rises. A 1-to-0 transition and a steady level set nothing.
- R5: A read of offset 0x08 returns the status word as it stood before the read. All event bits are cleared from the following cycle.
- R6: An event that arrives in the same cycle as a status read is still set after that read.
- R7: Writing 1s to offset 0x0C sets the matching mask bits, and writing 1s to offset 0x10 clears them. Bits written as 0 leave the mask unchanged. Offset 0x14 reads the mask. Only bits 16, 17 and 24 exist in the mask, and offsets 0x0C and 0x10 read as 0.
- R8: Writes to the status offset 0x08 and the mask offset 0x14 change nothing.
- R9: The interrupt output is 1 exactly when some status bit and the same mask bit are both 1. It follows the stored state in the same cycle that the state changes.
- R10: Offset 0x18 stores the low 8 bits of the written word, reads them back, and drives them on the first-address output. Offset 0x1C stores bit 0, reads it back, and drives the bank select.
- R11: A read of any other offset, including an unaligned one, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears events) |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, combinational from the offset |
| xfer_done_i | input | 1 | Transfer-done pulse from the sequencer |
| cmd_done_i | input | 1 | Command-done pulse from the sequencer |
| rb_i | input | 1 | Asynchronous flash ready/busy, 1 = ready |
| irq_o | output | 1 | Interrupt request |
| ctl_en_o | output | 1 | Controller switched on |
| cyc0_o | output | 8 | First address byte |
| bank_o | output | 1 | Bank select |

## Verification
Read data is combinational, so the bench compares it in the same cycle as the read strobe, before the clock edge that applies the clear. Register writes, events, the controller-on state and the interrupt all take effect at the first edge after the stimulus. The bench therefore compares them at the falling edge that follows that rising edge. A ready edge crosses three flops, so the bench model keeps a short history of the sampled ready level and predicts bit 24 at the third edge after the input rose. Stimulus is driven only at falling edges, so every value the model predicts belongs to exactly one rising edge.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  // event slots: 0 transfer done, 1 command done, 2 ready edge
  localparam int NEVT = 3;
  localparam int unsigned EVT_POS [NEVT] = '{16, 17, 24};
  localparam int EV_XFER = 0;
  localparam int EV_CMD  = 1;
  localparam int EV_RDY  = 2;

  localparam int unsigned OFS_CTRL = 32'h04;
  localparam int unsigned OFS_STAT = 32'h08;
  localparam int unsigned OFS_MSET = 32'h0C;
  localparam int unsigned OFS_MCLR = 32'h10;
  localparam int unsigned OFS_MASK = 32'h14;
  localparam int unsigned OFS_CYC0 = 32'h18;
  localparam int unsigned OFS_BANK = 32'h1C;

  localparam int CYC0_W = 8;

  typedef logic [NEVT-1:0] evt_vec_t;
endpackage

// File: rtl/fsi_rdy_edge.sv
module fsi_rdy_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
  logic [STAGES:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], rb_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fsi_evt_status.sv
module fsi_evt_status
  import fsi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t evt_i,
  input  logic     clr_i,
  output evt_vec_t st_o
);
  evt_vec_t st_q, st_d;

  // set has priority over the clear of a read in the same cycle
  always_comb begin
    st_d = st_q;
    if (clr_i) st_d = '0;
    st_d = st_d | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  for (genvar k = 0; k < NEVT; k++) begin : g_chk
    p_evt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[k] |=> st_q[k]);
    p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i[k]) |=> !st_q[k]);
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[k] && !clr_i) |=> st_q[k]);
  end
endmodule

// File: rtl/fsi_irq_mask.sv
module fsi_irq_mask
  import fsi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_i,
  input  evt_vec_t clr_i,
  output evt_vec_t mk_o
);
  evt_vec_t mk_q, mk_d;

  always_comb begin
    mk_d = (mk_q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mk_q <= '0;
    else        mk_q <= mk_d;
  end

  assign mk_o = mk_q;

  for (genvar k = 0; k < NEVT; k++) begin : g_chk
    p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[k] && !clr_i[k]) |=> mk_q[k]);
    p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[k] |=> !mk_q[k]);
    p_mask_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[k] && !clr_i[k]) |=> $stable(mk_q[k]));
  end
endmodule

// File: rtl/flash_status_irq.sv
module flash_status_irq
  import fsi_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done_i,
  input  logic              cmd_done_i,
  input  logic              rb_i,
  output logic              irq_o,
  output logic              ctl_en_o,
  output logic [7:0]        cyc0_o,
  output logic              bank_o
);
  // address decode
  logic hit_ctrl, hit_stat, hit_mset, hit_mclr, hit_mask, hit_cyc0, hit_bank;
  assign hit_ctrl = (reg_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign hit_mset = (reg_addr == ADDR_W'(OFS_MSET));
  assign hit_mclr = (reg_addr == ADDR_W'(OFS_MCLR));
  assign hit_mask = (reg_addr == ADDR_W'(OFS_MASK));
  assign hit_cyc0 = (reg_addr == ADDR_W'(OFS_CYC0));
  assign hit_bank = (reg_addr == ADDR_W'(OFS_BANK));

  // ready edge
  logic rdy_rise;
  fsi_rdy_edge #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rb_i(rb_i), .rise_o(rdy_rise)
  );

  // events
  evt_vec_t evt, st, mk, mset, mclr;
  always_comb begin
    evt          = '0;
    evt[EV_XFER] = xfer_done_i;
    evt[EV_CMD]  = cmd_done_i;
    evt[EV_RDY]  = rdy_rise;
  end

  fsi_evt_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .clr_i(reg_rd && hit_stat), .st_o(st)
  );

  for (genvar k = 0; k < NEVT; k++) begin : g_mbits
    assign mset[k] = reg_wr && hit_mset && reg_wdata[EVT_POS[k]];
    assign mclr[k] = reg_wr && hit_mclr && reg_wdata[EVT_POS[k]];
  end

  fsi_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .set_i(mset), .clr_i(mclr), .mk_o(mk)
  );

  assign irq_o = |(st & mk);

  // control, first address byte, bank
  logic              en_q, en_d;
  logic [CYC0_W-1:0] cyc0_q, cyc0_d;
  logic              bank_q, bank_d;

  always_comb begin
    en_d   = en_q;
    cyc0_d = cyc0_q;
    bank_d = bank_q;
    if (reg_wr && hit_ctrl) begin
      if (reg_wdata[1])      en_d = 1'b0;
      else if (reg_wdata[0]) en_d = 1'b1;
    end
    if (reg_wr && hit_cyc0) cyc0_d = reg_wdata[CYC0_W-1:0];
    if (reg_wr && hit_bank) bank_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cyc0_q <= '0;
      bank_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cyc0_q <= cyc0_d;
      bank_q <= bank_d;
    end
  end

  assign ctl_en_o = en_q;
  assign cyc0_o   = cyc0_q;
  assign bank_o   = bank_q;

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      for (int k = 0; k < NEVT; k++) reg_rdata[EVT_POS[k]] = st[k];
    end else if (hit_mask) begin
      for (int k = 0; k < NEVT; k++) reg_rdata[EVT_POS[k]] = mk[k];
    end else if (hit_cyc0) begin
      reg_rdata[CYC0_W-1:0] = cyc0_q;
    end else if (hit_bank) begin
      reg_rdata[0] = bank_q;
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  p_ctl_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_ctrl && reg_wdata[1]) |=> !ctl_en_o);
  p_ctl_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_ctrl && reg_wdata[0] && !reg_wdata[1]) |=> ctl_en_o);
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mk == '0) |-> !irq_o);
  p_cyc0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && hit_cyc0) |=> $stable(cyc0_o));
endmodule

// File: tb/flash_status_irq_test.sv
`timescale 1ns/1ps
module flash_status_irq_test;
  localparam logic [31:0] EVM = 32'h0103_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, xfer, cmd, rb;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, ctl_en, bank;
  logic [7:0]  cyc0;

  always #4 clk = ~clk;

  flash_status_irq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done_i(xfer), .cmd_done_i(cmd), .rb_i(rb), .irq_o(irq),
    .ctl_en_o(ctl_en), .cyc0_o(cyc0), .bank_o(bank)
  );

  int n_chk = 0, n_fail = 0;

  // bench model
  logic [31:0] m_st, m_mk;
  logic        m_en, m_bank;
  logic [7:0]  m_cyc0;
  logic        h0, h1, h2;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h08:   return m_st;
      5'h14:   return m_mk;
      5'h18:   return {24'h0, m_cyc0};
      5'h1C:   return {31'h0, m_bank};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(input logic [4:0] a);
    case (a)
      5'h04:        return "R2 ctrl read";
      5'h08:        return "R5 status read";
      5'h0C, 5'h10: return "R7 set/clear read";
      5'h14:        return "R7 mask read";
      5'h18, 5'h1C: return "R10 readback";
      default:      return "R11 unmapped read";
    endcase
  endfunction

  task automatic model_reset();
    m_st = 0; m_mk = 0; m_en = 0; m_bank = 0; m_cyc0 = 0;
    h0 = 1; h1 = 1; h2 = 1;
  endtask

  // one clock: drive at a falling edge, check read data before the rise,
  // update model at the rise, check outputs at the next fall
  task automatic cycle(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [31:0] d, input logic xf, input logic cm,
                       input logic r, output logic [31:0] got);
    logic [31:0] set;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    xfer = xf; cmd = cm; rb = r;
    #1;
    got = reg_rdata;
    if (rd) chk(read_tag(a), reg_rdata, exp_read(a));
    @(posedge clk);
    set = {7'h0, h1 & ~h2, 6'h0, cm, xf, 16'h0};
    h2 = h1; h1 = h0; h0 = r;
    if (rd && a == 5'h08) m_st = 0;
    m_st |= set;
    if (wr) begin
      case (a)
        5'h04: if (d[1]) m_en = 0; else if (d[0]) m_en = 1;
        5'h0C: m_mk |= d & EVM;
        5'h10: m_mk &= ~(d & EVM);
        5'h18: m_cyc0 = d[7:0];
        5'h1C: m_bank = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R9 irq", {31'h0, irq}, {31'h0, |(m_st & m_mk)});
    chk("R2 ctl_en", {31'h0, ctl_en}, {31'h0, m_en});
    chk("R10 cyc0", {24'h0, cyc0}, {24'h0, m_cyc0});
    chk("R10 bank", {31'h0, bank}, {31'h0, m_bank});
  endtask

  logic rb_lvl;
  task automatic idle(input int n);
    logic [31:0] g;
    for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, 0, 0, rb_lvl, g);
  endtask
  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] g;
    cycle(1, 0, a, d, 0, 0, rb_lvl, g);
  endtask
  task automatic rd_exp(input logic [4:0] a, input logic [31:0] e, input string tag);
    logic [31:0] g;
    cycle(0, 1, a, 0, 0, 0, rb_lvl, g);
    chk(tag, g, e);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] g;
    void'($urandom(32'd20240611));
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    xfer = 0; cmd = 0; rb = 1; rb_lvl = 1;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 ctl_en", {31'h0, ctl_en}, 0);
    chk("R1 cyc0", {24'h0, cyc0}, 0);
    chk("R1 bank", {31'h0, bank}, 0);
    rd_exp(5'h08, 0, "R1 status");
    rd_exp(5'h14, 0, "R1 mask");

    // R2 control strobes
    wr_reg(5'h04, 32'h1); chk("R2 on", {31'h0, ctl_en}, 1);
    wr_reg(5'h04, 32'h3); chk("R2 both->off", {31'h0, ctl_en}, 0);
    wr_reg(5'h04, 32'h1); wr_reg(5'h04, 32'h2);
    chk("R2 off", {31'h0, ctl_en}, 0);
    rd_exp(5'h04, 0, "R2 ctrl reads 0");

    // R3 event latching, R5 clear on read
    cycle(0, 0, 0, 0, 1, 0, 1, g); idle(2);
    rd_exp(5'h08, 32'h0001_0000, "R3 xfer bit16");
    rd_exp(5'h08, 32'h0, "R5 cleared");
    cycle(0, 0, 0, 0, 0, 1, 1, g);
    rd_exp(5'h08, 32'h0002_0000, "R3 cmd bit17");

    // R6 event coincident with status read
    cycle(0, 1, 5'h08, 0, 0, 1, 1, g);
    chk("R6 read sees old", g, 32'h0);
    rd_exp(5'h08, 32'h0002_0000, "R6 kept");

    // R4 ready edge timing
    rb_lvl = 0; idle(5);
    rd_exp(5'h08, 32'h0, "R4 fall no event");
    rb_lvl = 1; idle(2);
    rd_exp(5'h08, 32'h0, "R4 not yet");
    rd_exp(5'h08, 32'h0100_0000, "R4 bit24 third edge");
    idle(4);
    rd_exp(5'h08, 32'h0, "R4 steady no event");

    // R7 mask set/clear, R8 ignored writes
    wr_reg(5'h0C, 32'hFFFF_FFFF);
    rd_exp(5'h14, 32'h0103_0000, "R7 set all");
    wr_reg(5'h10, 32'h0001_0000);
    rd_exp(5'h14, 32'h0102_0000, "R7 clear bit16");
    wr_reg(5'h0C, 32'h0);
    rd_exp(5'h14, 32'h0102_0000, "R7 zero write");
    rd_exp(5'h0C, 32'h0, "R7 set port reads 0");
    wr_reg(5'h14, 32'hFFFF_FFFF);
    rd_exp(5'h14, 32'h0102_0000, "R8 mask write ignored");
    cycle(0, 0, 0, 0, 0, 1, 1, g);
    wr_reg(5'h08, 32'h0);
    rd_exp(5'h08, 32'h0002_0000, "R8 status write ignored");

    // R9 interrupt
    cycle(0, 0, 0, 0, 1, 0, 1, g);
    chk("R9 masked event no irq", {31'h0, irq}, 0);
    cycle(0, 0, 0, 0, 0, 1, 1, g);
    chk("R9 irq up", {31'h0, irq}, 1);
    rd_exp(5'h08, 32'h0003_0000, "R9 status");
    chk("R9 irq cleared", {31'h0, irq}, 0);

    // R10 address byte and bank
    wr_reg(5'h18, 32'h0000_01A5);
    chk("R10 cyc0 low byte", {24'h0, cyc0}, 32'hA5);
    rd_exp(5'h18, 32'hA5, "R10 cyc0 read");
    wr_reg(5'h1C, 32'h3);
    rd_exp(5'h1C, 32'h1, "R10 bank bit0");

    // R11 unmapped reads
    rd_exp(5'h00, 0, "R11 offset 0");
    rd_exp(5'h19, 0, "R11 unaligned");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom;
      logic [4:0] a = (r[2:0] == 3'd7) ? 5'($urandom % 32) : {r[5:3], 2'b00};
      logic op_wr = (r[9:8] == 2'd1);
      logic op_rd = (r[9:8] >= 2'd2);
      if (r[15:12] == 0) rb_lvl = ~rb_lvl;
      cycle(op_wr, op_rd, a, $urandom, r[20:18] == 0, r[23:21] == 0, rb_lvl, g);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule